// File: doc/BRIEF.md
# PCIe Cold-Reset Sequencer

This block is a hardware state machine that brings a PCIe controller out of reset in a fixed order, and that puts it back into reset on command. It drives the controller's individual reset lines (power, hot, PHY, PIPE, core, sticky and non-sticky), a one-cycle application-domain reset pulse, the enables of the application and reference clocks, the peripheral reset line and a link-training enable. Two request flags from a power-management unit hold the sequence back: the PHY reset is not released while the PHY request flag is set, and the PIPE and core resets are not released while the core request flag is set.

Every delay is a cycle count derived from the clock rate in cycles per microsecond. Each flag wait samples the flag once per microsecond and gives up after a timeout. On a timeout the block walks back through the steps it had already taken, one per cycle in reverse order, re-asserting only the resets it had released and disabling only the clocks it had enabled. It then reports the failing wait in an error code. A stop command first clears link training, then asserts every reset, and then waits a long settle period before it reports stopped. The first stop after power-up leaves the clock enables alone; later stops gate both clocks off.

Top module: `pcie_crs_seq`

## Requirements
- R1: After reset every reset output and perst_o are 1 (1 = held in reset), both clock enables, app_rst_o, train_en_o, ready_o, stopped_o and fail_o are 0, and err_code_o is 0.
- R2: On stop_i, accepted in the idle, ready, stopped and failed states, train_en_o goes to 0 in an earlier cycle than the resets reassert. All seven resets and perst_o then go to 1, and stopped_o rises exactly STOP_SETTLE_US*CYC_PER_US cycles after they reassert.
- R3: The first stop after power-up leaves app_clk_en_o and ref_clk_en_o unchanged. Every later stop drives both to 0.
- R4: On start_i, accepted in the idle, stopped and failed states, the releases happen in strictly increasing cycles in this order: power reset, hot reset, PHY reset, application clock enable, reference clock enable, PIPE reset, core reset, sticky reset, non-sticky reset, peripheral reset.
- R5: The PHY reset stays asserted while phy_req_i is 1. After phy_req_i falls, the PHY reset is released within CYC_PER_US+3 cycles.
- R6: The PIPE reset stays asserted while core_req_i is 1, with both clocks already enabled. After core_req_i falls, the PIPE reset is released within CYC_PER_US+3 cycles.
- R7: app_rst_o is high for exactly one cycle per start sequence. That cycle lies after the core reset is released and before the sticky reset is released.
- R8: ready_o rises exactly RUN_SETTLE_US*CYC_PER_US cycles after perst_o falls, with train_en_o still 0.
- R9: If a request flag stays 1 for POLL_TIMEOUT_US*CYC_PER_US cycles of its wait, fail_o rises no earlier than that and no later than 6 cycles after it. err_code_o then reads 1 for the PHY wait and 2 for the core wait, and holds until the next start.
- R10: On a timeout the block disables, one per cycle in reverse order, only what it had released or enabled. After a PHY-wait timeout the clock enables keep their values. After a core-wait timeout the reference clock is disabled before the application clock, followed by the PHY, hot and power resets.
- R11: train_go_i sets train_en_o only in the ready state and is ignored in every other state.
- R12: start_i in the ready state is ignored: ready_o stays 1 and no new app_rst_o pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start the cold-reset sequence |
| stop_i | input | 1 | Stop the bus and return to reset |
| train_go_i | input | 1 | Enable link training (ready state only) |
| phy_req_i | input | 1 | Power-management PHY reset request flag |
| core_req_i | input | 1 | Power-management core reset request flag |
| train_en_o | output | 1 | Link-training enable |
| rst_pwr_o | output | 1 | Power reset, 1 = asserted |
| rst_hot_o | output | 1 | Hot reset, 1 = asserted |
| rst_phy_o | output | 1 | PHY reset, 1 = asserted |
| rst_pipe_o | output | 1 | PIPE reset, 1 = asserted |
| rst_core_o | output | 1 | Core reset, 1 = asserted |
| rst_sticky_o | output | 1 | Sticky register reset, 1 = asserted |
| rst_nsticky_o | output | 1 | Non-sticky register reset, 1 = asserted |
| app_rst_o | output | 1 | One-cycle application-domain reset pulse |
| app_clk_en_o | output | 1 | Application clock enable |
| ref_clk_en_o | output | 1 | Reference clock enable |
| perst_o | output | 1 | Peripheral reset, 1 = asserted |
| ready_o | output | 1 | Start sequence complete |
| stopped_o | output | 1 | Stop sequence complete |
| fail_o | output | 1 | Start sequence failed and unwound |
| err_code_o | output | 2 | Failing wait: 0 none, 1 PHY wait, 2 core wait |

## Verification
The reset and clock outputs come from a single progress level, so a wrong level or a wrong state step shows at once. A release appears out of order, a step is skipped, or the unwind walks past a step it never took, and all of these are visible in the cycle after the faulty transition. Timer or poll faults show only at the end of a wait: ready_o or stopped_o a cycle early or late, a release too long after a flag drops, or fail_o before the timeout has run out. For that reason each interval is measured in exact cycles from the event that starts it.

// File: rtl/pcie_crs_pkg.sv
package pcie_crs_pkg;

  typedef enum logic [4:0] {
    S_IDLE, S_PWR, S_HOT, S_WPHY, S_PHY, S_APPCK, S_REFCK, S_WCORE,
    S_PIPE, S_CORE, S_APPRST, S_STK, S_NSTK, S_PERST, S_RUNWAIT,
    S_READY, S_UNWIND, S_FAIL, S_STOP1, S_STOP2, S_STOPWAIT, S_OFF
  } seq_st_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_PHY  = 2'd1,
    ERR_CORE = 2'd2
  } err_e;

  localparam int unsigned LVL_W   = 4;
  localparam int unsigned N_RST   = 8;

  // progress level at which each item is released or enabled
  localparam logic [LVL_W-1:0] LVL_PWR  = 4'd1;
  localparam logic [LVL_W-1:0] LVL_HOT  = 4'd2;
  localparam logic [LVL_W-1:0] LVL_PHY  = 4'd3;
  localparam logic [LVL_W-1:0] LVL_APP  = 4'd4;
  localparam logic [LVL_W-1:0] LVL_REF  = 4'd5;
  localparam logic [LVL_W-1:0] LVL_PIPE = 4'd6;
  localparam logic [LVL_W-1:0] LVL_CORE = 4'd7;
  localparam logic [LVL_W-1:0] LVL_STK  = 4'd8;
  localparam logic [LVL_W-1:0] LVL_NSTK = 4'd9;
  localparam logic [LVL_W-1:0] LVL_PER  = 4'd10;

  // reset-vector slot to release level:
  // 0 pwr, 1 hot, 2 phy, 3 pipe, 4 core, 5 sticky, 6 non-sticky, 7 peripheral
  function automatic logic [LVL_W-1:0] rst_level(input int unsigned slot);
    case (slot)
      0: return LVL_PWR;
      1: return LVL_HOT;
      2: return LVL_PHY;
      3: return LVL_PIPE;
      4: return LVL_CORE;
      5: return LVL_STK;
      6: return LVL_NSTK;
      default: return LVL_PER;
    endcase
  endfunction

  function automatic logic held_at(input logic [LVL_W-1:0] lvl,
                                   input logic [LVL_W-1:0] rel);
    return lvl < rel;
  endfunction

  function automatic longint unsigned us_to_cyc(input longint unsigned us,
                                                input longint unsigned cpu);
    return us * cpu;
  endfunction

endpackage

// File: rtl/pcie_crs_timer.sv
module pcie_crs_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt;

  assign hit = run && (cnt == limit - W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (!hit)     cnt <= cnt + W'(1);
  end

  // R8: the count never runs past the programmed window
  assert_cnt_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < limit));

endmodule

// File: rtl/pcie_crs_poll.sv
module pcie_crs_poll #(
  parameter int unsigned TW  = 8,
  parameter int unsigned TKW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           flag,
  input  logic [TKW-1:0] tick_len,
  input  logic [TW-1:0]  limit,
  output logic           cleared,
  output logic           expired
);
  logic [TKW-1:0] tk;
  logic           strobe;
  logic           win_hit;

  assign strobe  = run && (tk == tick_len - TKW'(1));
  assign cleared = strobe && !flag;
  assign expired = win_hit && !cleared;

  always_ff @(posedge clk) begin
    if (!rst_n)       tk <= '0;
    else if (!run)    tk <= '0;
    else if (strobe)  tk <= '0;
    else              tk <= tk + TKW'(1);
  end

  pcie_crs_timer #(.W(TW)) u_window (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .limit (limit),
    .hit   (win_hit)
  );

  // R9: the timeout lands on a poll sample, so the flag is read one last time
  assert_expire_on_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> strobe);

endmodule

// File: rtl/pcie_crs_seq.sv
module pcie_crs_seq
  import pcie_crs_pkg::*;
#(
  parameter int unsigned CYC_PER_US      = 100,
  parameter int unsigned STOP_SETTLE_US  = 100000,
  parameter int unsigned RUN_SETTLE_US   = 100,
  parameter int unsigned POLL_TIMEOUT_US = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       train_go_i,
  input  logic       phy_req_i,
  input  logic       core_req_i,
  output logic       train_en_o,
  output logic       rst_pwr_o,
  output logic       rst_hot_o,
  output logic       rst_phy_o,
  output logic       rst_pipe_o,
  output logic       rst_core_o,
  output logic       rst_sticky_o,
  output logic       rst_nsticky_o,
  output logic       app_rst_o,
  output logic       app_clk_en_o,
  output logic       ref_clk_en_o,
  output logic       perst_o,
  output logic       ready_o,
  output logic       stopped_o,
  output logic       fail_o,
  output logic [1:0] err_code_o
);
  localparam longint unsigned STOP_CYC = us_to_cyc(STOP_SETTLE_US, CYC_PER_US);
  localparam longint unsigned RUN_CYC  = us_to_cyc(RUN_SETTLE_US, CYC_PER_US);
  localparam longint unsigned POLL_CYC = us_to_cyc(POLL_TIMEOUT_US, CYC_PER_US);
  localparam longint unsigned MAX_CYC  =
    (STOP_CYC > RUN_CYC) ? ((STOP_CYC > POLL_CYC) ? STOP_CYC : POLL_CYC)
                         : ((RUN_CYC > POLL_CYC) ? RUN_CYC : POLL_CYC);
  localparam int unsigned TW  = $clog2(MAX_CYC + 1);
  localparam int unsigned TKW = $clog2(CYC_PER_US + 1);

  seq_st_e          st;
  logic [LVL_W-1:0] lvl;
  logic             app_ck, ref_ck, seen_stop, train, app_pulse;
  err_e             err;

  // named internal events
  logic           can_start, can_stop, settle_run, settle_hit;
  logic           poll_run, poll_flag, poll_clear, poll_expire;
  logic [TW-1:0]  settle_lim;
  logic [N_RST-1:0] rst_vec;

  assign can_start  = (st == S_IDLE) || (st == S_OFF) || (st == S_FAIL);
  assign can_stop   = can_start || (st == S_READY);
  assign settle_run = (st == S_RUNWAIT) || (st == S_STOPWAIT);
  assign settle_lim = (st == S_STOPWAIT) ? TW'(STOP_CYC) : TW'(RUN_CYC);
  assign poll_run   = (st == S_WPHY) || (st == S_WCORE);
  assign poll_flag  = (st == S_WPHY) ? phy_req_i : core_req_i;

  pcie_crs_timer #(.W(TW)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (settle_run),
    .limit (settle_lim),
    .hit   (settle_hit)
  );

  pcie_crs_poll #(.TW(TW), .TKW(TKW)) u_poll (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (poll_run),
    .flag     (poll_flag),
    .tick_len (TKW'(CYC_PER_US)),
    .limit    (TW'(POLL_CYC)),
    .cleared  (poll_clear),
    .expired  (poll_expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      lvl       <= '0;
      app_ck    <= 1'b0;
      ref_ck    <= 1'b0;
      seen_stop <= 1'b0;
      train     <= 1'b0;
      app_pulse <= 1'b0;
      err       <= ERR_NONE;
    end else begin
      app_pulse <= (st == S_APPRST);
      case (st)
        S_IDLE, S_OFF, S_FAIL: begin
          if (start_i) begin
            err <= ERR_NONE;
            st  <= S_PWR;
          end else if (stop_i) begin
            st  <= S_STOP1;
          end
        end
        S_READY: begin
          if (stop_i)          st    <= S_STOP1;
          else if (train_go_i) train <= 1'b1;
        end
        S_PWR:   begin lvl <= LVL_PWR;  st <= S_HOT;  end
        S_HOT:   begin lvl <= LVL_HOT;  st <= S_WPHY; end
        S_WPHY: begin
          if (poll_clear) st <= S_PHY;
          else if (poll_expire) begin
            err <= ERR_PHY;
            st  <= S_UNWIND;
          end
        end
        S_PHY:   begin lvl <= LVL_PHY;  st <= S_APPCK; end
        S_APPCK: begin lvl <= LVL_APP;  app_ck <= 1'b1; st <= S_REFCK; end
        S_REFCK: begin lvl <= LVL_REF;  ref_ck <= 1'b1; st <= S_WCORE; end
        S_WCORE: begin
          if (poll_clear) st <= S_PIPE;
          else if (poll_expire) begin
            err <= ERR_CORE;
            st  <= S_UNWIND;
          end
        end
        S_PIPE:  begin lvl <= LVL_PIPE; st <= S_CORE;   end
        S_CORE:  begin lvl <= LVL_CORE; st <= S_APPRST; end
        S_APPRST:                       st <= S_STK;
        S_STK:   begin lvl <= LVL_STK;  st <= S_NSTK;   end
        S_NSTK:  begin lvl <= LVL_NSTK; st <= S_PERST;  end
        S_PERST: begin lvl <= LVL_PER;  st <= S_RUNWAIT; end
        S_RUNWAIT: if (settle_hit) st <= S_READY;
        S_UNWIND: begin
          if (lvl == '0) st <= S_FAIL;
          else begin
            lvl <= lvl - LVL_W'(1);
            if (lvl == LVL_REF) ref_ck <= 1'b0;
            if (lvl == LVL_APP) app_ck <= 1'b0;
          end
        end
        S_STOP1: begin train <= 1'b0; st <= S_STOP2; end
        S_STOP2: begin
          lvl <= '0;
          if (seen_stop) begin
            app_ck <= 1'b0;
            ref_ck <= 1'b0;
          end
          seen_stop <= 1'b1;
          st        <= S_STOPWAIT;
        end
        S_STOPWAIT: if (settle_hit) st <= S_OFF;
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < N_RST; g++) begin : g_rst
    assign rst_vec[g] = held_at(lvl, rst_level(g));
  end

  assign rst_pwr_o     = rst_vec[0];
  assign rst_hot_o     = rst_vec[1];
  assign rst_phy_o     = rst_vec[2];
  assign rst_pipe_o    = rst_vec[3];
  assign rst_core_o    = rst_vec[4];
  assign rst_sticky_o  = rst_vec[5];
  assign rst_nsticky_o = rst_vec[6];
  assign perst_o       = rst_vec[7];
  assign app_clk_en_o  = app_ck;
  assign ref_clk_en_o  = ref_ck;
  assign app_rst_o     = app_pulse;
  assign train_en_o    = train;
  assign ready_o       = (st == S_READY);
  assign stopped_o     = (st == S_OFF);
  assign fail_o        = (st == S_FAIL);
  assign err_code_o    = err;

  // R7: the application reset is a single-cycle pulse
  assert_app_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    app_rst_o |=> !app_rst_o);

  // R4: reference clock never comes up without the application clock
  assert_clk_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_clk_en_o) |-> app_clk_en_o);

  // R8: the sequence completes with link training disabled
  assert_ready_untrained_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> !train_en_o);

  // R10: unwinding never releases anything
  assert_unwind_monotonic_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_UNWIND) |=> (lvl <= $past(lvl)));

  // R9: the error code is held while failed and no new start arrives
  assert_err_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !start_i) |=> $stable(err_code_o));

  // R2: training is off before the resets go back on
  assert_stop_untrained_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOP2) |-> !train_en_o);

endmodule

// File: tb/pcie_crs_seq_bench.sv
module pcie_crs_seq_bench;
  localparam int PERIOD  = 10;
  localparam int CPU     = 4;
  localparam int STOP_US = 10;
  localparam int RUN_US  = 5;
  localparam int POLL_US = 25;
  localparam int STOP_C  = STOP_US * CPU;
  localparam int RUN_C   = RUN_US * CPU;
  localparam int POLL_C  = POLL_US * CPU;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, stop_i = 0, train_go_i = 0, phy_req_i = 0, core_req_i = 0;
  logic train_en_o, rst_pwr_o, rst_hot_o, rst_phy_o, rst_pipe_o, rst_core_o;
  logic rst_sticky_o, rst_nsticky_o, app_rst_o, app_clk_en_o, ref_clk_en_o;
  logic perst_o, ready_o, stopped_o, fail_o;
  logic [1:0] err_code_o;

  always #(PERIOD/2) clk = ~clk;

  pcie_crs_seq #(
    .CYC_PER_US(CPU), .STOP_SETTLE_US(STOP_US),
    .RUN_SETTLE_US(RUN_US), .POLL_TIMEOUT_US(POLL_US)
  ) u_pcie_crs_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .train_go_i(train_go_i), .phy_req_i(phy_req_i), .core_req_i(core_req_i),
    .train_en_o(train_en_o), .rst_pwr_o(rst_pwr_o), .rst_hot_o(rst_hot_o),
    .rst_phy_o(rst_phy_o), .rst_pipe_o(rst_pipe_o), .rst_core_o(rst_core_o),
    .rst_sticky_o(rst_sticky_o), .rst_nsticky_o(rst_nsticky_o),
    .app_rst_o(app_rst_o), .app_clk_en_o(app_clk_en_o),
    .ref_clk_en_o(ref_clk_en_o), .perst_o(perst_o), .ready_o(ready_o),
    .stopped_o(stopped_o), .fail_o(fail_o), .err_code_o(err_code_o)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // release vector: 0 pwr,1 hot,2 phy,3 app clk,4 ref clk,5 pipe,6 core,7 sticky,8 nsticky,9 perst
  logic [9:0] rel, prev_rel;
  int t_on[10], t_off[10];
  int t_pulse, n_pulse, t_ready, t_stop, t_fail, t_trainoff;
  logic prev_ready, prev_stop, prev_fail, prev_train;

  assign rel = {~perst_o, ~rst_nsticky_o, ~rst_sticky_o, ~rst_core_o, ~rst_pipe_o,
                ref_clk_en_o, app_clk_en_o, ~rst_phy_o, ~rst_hot_o, ~rst_pwr_o};

  task automatic clr_mon();
    for (int i = 0; i < 10; i++) begin t_on[i] = -1; t_off[i] = -1; end
    t_pulse = -1; n_pulse = 0; t_ready = -1; t_stop = -1; t_fail = -1; t_trainoff = -1;
  endtask

  initial begin
    clr_mon();
    prev_rel = '0; prev_ready = 0; prev_stop = 0; prev_fail = 0; prev_train = 0;
  end

  always @(negedge clk) if (rst_n) begin
    for (int i = 0; i < 10; i++) begin
      if (rel[i] && !prev_rel[i]) t_on[i] = cyc;
      if (!rel[i] && prev_rel[i]) t_off[i] = cyc;
    end
    if (app_rst_o) begin n_pulse++; t_pulse = cyc; end
    if (ready_o && !prev_ready) t_ready = cyc;
    if (stopped_o && !prev_stop) t_stop = cyc;
    if (fail_o && !prev_fail) t_fail = cyc;
    if (!train_en_o && prev_train) t_trainoff = cyc;
    prev_rel = rel; prev_ready = ready_o; prev_stop = stopped_o;
    prev_fail = fail_o; prev_train = train_en_o;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_in(input int which);
    @(negedge clk);
    case (which)
      0: start_i = 1;
      1: stop_i = 1;
      default: train_go_i = 1;
    endcase
    @(negedge clk);
    start_i = 0; stop_i = 0; train_go_i = 0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 3000 && !ready_o; i++) @(negedge clk);
  endtask
  task automatic wait_stopped();
    for (int i = 0; i < 3000 && !stopped_o; i++) @(negedge clk);
  endtask
  task automatic wait_fail();
    for (int i = 0; i < 3000 && !fail_o; i++) @(negedge clk);
  endtask

  task automatic check_order(input string tag);
    for (int i = 1; i < 10; i++)
      chk(t_on[i-1] >= 0 && t_on[i] > t_on[i-1], "R4", tag, t_on[i], t_on[i-1] + 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk({rst_pwr_o, rst_hot_o, rst_phy_o, rst_pipe_o, rst_core_o, rst_sticky_o,
         rst_nsticky_o, perst_o} == 8'hFF, "R1", "resets asserted",
        {rst_pwr_o, rst_hot_o, rst_phy_o, rst_pipe_o, rst_core_o, rst_sticky_o,
         rst_nsticky_o, perst_o}, 255);
    chk({app_clk_en_o, ref_clk_en_o, app_rst_o, train_en_o, ready_o, stopped_o,
         fail_o} == 0, "R1", "idle outputs low",
        {app_clk_en_o, ref_clk_en_o, app_rst_o, train_en_o, ready_o, stopped_o, fail_o}, 0);
    chk(err_code_o == 0, "R1", "err code", err_code_o, 0);
  endtask

  task automatic t_first_start();
    int np;
    clr_mon();
    pulse_in(0);
    wait_ready();
    @(negedge clk);
    chk(ready_o == 1, "R8", "ready reached", ready_o, 1);
    check_order("first start order");
    chk(n_pulse == 1, "R7", "pulse count", n_pulse, 1);
    chk(t_pulse > t_on[6] && t_pulse < t_on[7], "R7", "pulse placement", t_pulse, t_on[6] + 1);
    chk(t_ready - t_on[9] == RUN_C, "R8", "run settle", t_ready - t_on[9], RUN_C);
    chk(train_en_o == 0, "R8", "training off at ready", train_en_o, 0);
    np = n_pulse;
    pulse_in(0);
    repeat (5) @(negedge clk);
    chk(ready_o == 1 && n_pulse == np, "R12", "start in ready ignored", n_pulse, np);
    pulse_in(2);
    @(negedge clk);
    chk(train_en_o == 1, "R11", "training enabled in ready", train_en_o, 1);
  endtask

  task automatic t_first_stop();
    clr_mon();
    pulse_in(1);
    wait_stopped();
    @(negedge clk);
    chk(stopped_o == 1, "R2", "stopped reached", stopped_o, 1);
    chk(t_trainoff >= 0 && t_trainoff < t_off[0], "R2", "training cleared first", t_trainoff, t_off[0] - 1);
    chk(rel == 10'b0000011000, "R3", "resets on, clocks kept", rel, 24);
    chk(t_stop - t_off[0] == STOP_C, "R2", "stop settle", t_stop - t_off[0], STOP_C);
    pulse_in(2);
    @(negedge clk);
    chk(train_en_o == 0, "R11", "training request ignored when stopped", train_en_o, 0);
  endtask

  task automatic t_phy_timeout();
    clr_mon();
    phy_req_i = 1;
    pulse_in(0);
    wait_fail();
    @(negedge clk);
    chk(fail_o == 1 && err_code_o == 1, "R9", "phy timeout code", err_code_o, 1);
    chk(t_fail - t_on[1] >= POLL_C && t_fail - t_on[1] <= POLL_C + 6, "R9",
        "phy timeout delay", t_fail - t_on[1], POLL_C + 3);
    chk(rel == 10'b0000011000, "R10", "phy unwind leaves clocks", rel, 24);
    chk(t_off[1] < t_off[0], "R10", "hot before pwr", t_off[1], t_off[0] - 1);
    phy_req_i = 0;
  endtask

  task automatic t_core_timeout();
    clr_mon();
    core_req_i = 1;
    pulse_in(0);
    wait_fail();
    @(negedge clk);
    chk(fail_o == 1 && err_code_o == 2, "R9", "core timeout code", err_code_o, 2);
    chk(rel == 0, "R10", "core unwind all off", rel, 0);
    for (int i = 4; i > 0; i--)
      chk(t_off[i] >= 0 && t_off[i] < t_off[i-1], "R10", "reverse unwind", t_off[i], t_off[i-1] - 1);
    core_req_i = 0;
  endtask

  task automatic t_flag_waits();
    int tr;
    clr_mon();
    phy_req_i = 1; core_req_i = 1;
    pulse_in(0);
    repeat (30) @(negedge clk);
    chk(rst_phy_o == 1 && rst_hot_o == 0, "R5", "phy held while requested", rst_phy_o, 1);
    tr = cyc; phy_req_i = 0;
    repeat (30) @(negedge clk);
    chk(t_on[2] > tr && t_on[2] - tr <= CPU + 3, "R5", "phy release latency", t_on[2] - tr, CPU);
    chk(rst_pipe_o == 1 && ref_clk_en_o == 1 && app_clk_en_o == 1, "R6",
        "pipe held, clocks on", rst_pipe_o, 1);
    tr = cyc; core_req_i = 0;
    wait_ready();
    @(negedge clk);
    chk(t_on[5] > tr && t_on[5] - tr <= CPU + 3, "R6", "pipe release latency", t_on[5] - tr, CPU);
    check_order("flag-wait start order");
    chk(ready_o == 1 && err_code_o == 0, "R9", "err cleared by start", err_code_o, 0);
    chk(n_pulse == 1, "R7", "pulse count after waits", n_pulse, 1);
  endtask

  task automatic t_second_stop();
    clr_mon();
    pulse_in(1);
    wait_stopped();
    @(negedge clk);
    chk(rel == 0, "R3", "second stop gates clocks", rel, 0);
    chk(t_stop - t_off[0] == STOP_C, "R2", "second stop settle", t_stop - t_off[0], STOP_C);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_first_start();
    t_first_stop();
    t_phy_timeout();
    t_core_timeout();
    t_flag_waits();
    t_second_stop();
    finish_run();
  end
endmodule